// File: doc/BRIEF.md
# Asynchronous Bus-Cycle Master

This block runs single read or write transfers on a 16-bit bus where the slave ends each cycle with an acknowledge strobe. It takes one request at a time on an internal port: address, direction, byte-lane selects and write data. It then plays the request out on the bus as a fixed sequence of half-clock states. The block's clock runs at twice the bus clock, so each tick stands for one half period. The even states fall in the high half of the bus clock and the odd states fall in the low half.

The address appears first. After it comes the address strobe, then the data strobes for the selected lanes. A read raises its data strobes together with the address strobe. A write first pulls the direction line low, drives its data one state later, and raises its data strobes one state after that. The slave's acknowledge and bus-error inputs are active low and asynchronous. They pass through a flop synchroniser and are acted on only at the end of the fourth state. While neither is present, the block adds whole bus-clock wait states. When the cycle closes, the strobes drop, read data is captured, and a one-tick completion pulse reports the result to the internal side.

Top module: `bus_cycle_master`

## Requirements
- R1: After reset the block is idle. `req_ready`=1, all three strobes are high, `bus_rd_wr_n`=1, `bus_data_oe`=0 and `rsp_done`=0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next tick until the tick in which the completion pulse appears.
- R3: In a read, the address strobe and the selected data strobes go low together on the second tick after acceptance, and they stay low until the strobes are released.
- R4: In a write, `bus_rd_wr_n` goes low on the second tick together with the address strobe. `bus_data_oe` rises on the third tick with `bus_data_out` equal to the request data. The selected data strobes go low on the fourth tick.
- R5: `req_be[1]` selects the upper strobe (bits 15..8) and `req_be[0]` selects the lower strobe (bits 7..0). A strobe whose lane is not selected stays high for the whole transfer.
- R6: Termination is taken from a 2-flop synchroniser and sampled only at the end of the fourth state. Each miss adds exactly two ticks. If `bus_ack_n` or `bus_err_n` goes low just after the k-th edge following acceptance (edge 0 is the accepting edge), the transfer has k/2 wait states (integer division), and the completion pulse appears 7+2·(k/2) edges after acceptance.
- R7: The address strobe and the data strobes go high on the tick that follows the last wait/S6 pair. `rsp_rdata` holds the value of `bus_data_in` as sampled at the end of the state before that tick.
- R8: One tick after the strobes are released, `bus_rd_wr_n` returns high, `bus_data_oe` falls, `req_ready` rises and `rsp_done` pulses for exactly one tick.
- R9: If the bus-error input is seen at sampling time (alone or together with the acknowledge), the completion carries `rsp_err`=1 and `rsp_valid`=0. An acknowledge alone gives `rsp_err`=0 and `rsp_valid`=1 for reads and `rsp_valid`=0 for writes.
- R10: A request offered while a transfer is in flight is ignored. `bus_addr` keeps the accepted address from the first tick after acceptance until completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Idle and able to take a request |
| req_addr | input | ADDR_W | Target address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Lane selects: bit 1 upper, bit 0 lower |
| req_wdata | input | DATA_W | Data for a write |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_err | output | 1 | The completion ended by bus error |
| rsp_valid | output | 1 | The completion carries good read data |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Address bus |
| bus_addr_stb_n | output | 1 | Address strobe, active low |
| bus_hi_stb_n | output | 1 | Upper lane data strobe, active low |
| bus_lo_stb_n | output | 1 | Lower lane data strobe, active low |
| bus_rd_wr_n | output | 1 | Direction: high read, low write |
| bus_data_oe | output | 1 | Drive enable for the data bus |
| bus_data_out | output | DATA_W | Write data driven when enabled |
| bus_data_in | input | DATA_W | Data bus as seen by the master |
| bus_ack_n | input | 1 | Slave acknowledge, active low, asynchronous |
| bus_err_n | input | 1 | Slave bus error, active low, asynchronous |

## Verification
The bench covers every combination of direction, three lane-select patterns, eight arrival points for the termination, and three kinds of termination (acknowledge, error, both). On each tick of each transfer it compares every bus pin against the state it predicts. The odd and even arrival points separate a design that counts wait states per half-clock from one that inserts whole bus clocks. The 0 and 1 points show the synchroniser latency that is just hidden by the fixed states. Changing the request inputs during a transfer separates a design that latches the request from one that passes it through. Read data is changed only in the last data state, so the bench detects a capture that happens on the wrong tick.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    // Half-clock states of one transfer; ST_WT is the low half of a wait clock
    typedef enum logic [3:0] {
        ST_S0 = 4'd0,
        ST_S1 = 4'd1,
        ST_S2 = 4'd2,
        ST_S3 = 4'd3,
        ST_S4 = 4'd4,
        ST_S5 = 4'd5,
        ST_S6 = 4'd6,
        ST_S7 = 4'd7,
        ST_WT = 4'd8
    } bcm_state_e;

    // Registered bus control pins
    typedef struct packed {
        logic as_n;
        logic hi_n;
        logic lo_n;
        logic rw;
        logic oe;
    } bcm_pins_t;

    localparam bcm_pins_t PINS_IDLE = '{as_n: 1'b1, hi_n: 1'b1, lo_n: 1'b1, rw: 1'b1, oe: 1'b0};

endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            assign chain_d = d;
        end else begin : g_many
            assign chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bcm_decode.sv
module bcm_decode
    import bcm_pkg::*;
(
    input  bcm_state_e state,
    input  logic       write,
    input  logic [1:0] be,
    output bcm_pins_t  pins
);

    logic as_on;
    logic ds_on;
    logic dir_low;
    logic drive_on;

    always_comb begin
        as_on    = state inside {ST_S2, ST_S3, ST_S4, ST_WT, ST_S5, ST_S6};
        ds_on    = write ? (state inside {ST_S4, ST_WT, ST_S5, ST_S6}) : as_on;
        dir_low  = write && (state inside {ST_S2, ST_S3, ST_S4, ST_WT, ST_S5, ST_S6, ST_S7});
        drive_on = write && (state inside {ST_S3, ST_S4, ST_WT, ST_S5, ST_S6, ST_S7});

        pins.as_n = ~as_on;
        pins.hi_n = ~(ds_on && be[1]);
        pins.lo_n = ~(ds_on && be[0]);
        pins.rw   = ~dir_low;
        pins.oe   = drive_on;
    end

endmodule

// File: rtl/bcm_seq.sv
module bcm_seq
    import bcm_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ack_s,
    input  logic              err_s,
    input  logic [DATA_W-1:0] bus_data_in,
    output bcm_pins_t         pins,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        bcm_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [1:0]        be;
        logic [DATA_W-1:0] wdata;
        logic              term_err;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              err;
        logic              rvalid;
    } core_t;

    core_t     core_d, core_q;
    bcm_pins_t pins_d, pins_q;
    logic      term_seen;

    assign term_seen = ack_s || err_s;

    always_comb begin
        core_d        = core_q;
        core_d.done   = 1'b0;
        core_d.err    = 1'b0;
        core_d.rvalid = 1'b0;
        case (core_q.state)
            ST_S0: begin
                if (req_valid) begin
                    core_d.state    = ST_S1;
                    core_d.addr     = req_addr;
                    core_d.write    = req_write;
                    core_d.be       = req_be;
                    core_d.wdata    = req_wdata;
                    core_d.term_err = 1'b0;
                end
            end
            ST_S1: core_d.state = ST_S2;
            ST_S2: core_d.state = ST_S3;
            ST_S3: core_d.state = ST_S4;
            ST_S4: begin
                if (term_seen) begin
                    core_d.state    = ST_S5;
                    core_d.term_err = err_s;
                end else begin
                    core_d.state = ST_WT;
                end
            end
            ST_WT: core_d.state = ST_S4;
            ST_S5: core_d.state = ST_S6;
            ST_S6: begin
                core_d.state = ST_S7;
                if (!core_q.write) core_d.rdata = bus_data_in;
            end
            ST_S7: begin
                core_d.state  = ST_S0;
                core_d.done   = 1'b1;
                core_d.err    = core_q.term_err;
                core_d.rvalid = !core_q.write && !core_q.term_err;
            end
            default: core_d.state = ST_S0;
        endcase
    end

    // Pins are decoded from the next state and registered, so they change on clean edges
    bcm_decode u_decode (
        .state (core_d.state),
        .write (core_d.write),
        .be    (core_d.be),
        .pins  (pins_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{state: ST_S0, default: '0};
            pins_q <= PINS_IDLE;
        end else begin
            core_q <= core_d;
            pins_q <= pins_d;
        end
    end

    assign req_ready    = (core_q.state == ST_S0);
    assign pins         = pins_q;
    assign bus_addr     = core_q.addr;
    assign bus_data_out = core_q.wdata;
    assign rsp_done     = core_q.done;
    assign rsp_err      = core_q.err;
    assign rsp_valid    = core_q.rvalid;
    assign rsp_rdata    = core_q.rdata;

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_q.as_n && $past(!pins_q.as_n)) |-> $stable(core_q.addr));

    // R5
    ds_inside_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_q.hi_n || !pins_q.lo_n) |-> !pins_q.as_n);

    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_q.rw && (!pins_q.hi_n || !pins_q.lo_n)) |-> pins_q.oe);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.done |=> !core_q.done);

    // R9
    err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.err |-> !core_q.rvalid);

    // R2
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_q.as_n |-> !req_ready);

    // R6
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_S4 && !term_seen) |=> (core_q.state == ST_WT));

endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
    import bcm_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_stb_n,
    output logic              bus_hi_stb_n,
    output logic              bus_lo_stb_n,
    output logic              bus_rd_wr_n,
    output logic              bus_data_oe,
    output logic [DATA_W-1:0] bus_data_out,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              bus_ack_n,
    input  logic              bus_err_n
);

    logic      ack_n_s;
    logic      err_n_s;
    bcm_pins_t pins;

    bcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_ack_n),
        .q     (ack_n_s)
    );

    bcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_err (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_err_n),
        .q     (err_n_s)
    );

    bcm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_be       (req_be),
        .req_wdata    (req_wdata),
        .ack_s        (~ack_n_s),
        .err_s        (~err_n_s),
        .bus_data_in  (bus_data_in),
        .pins         (pins),
        .bus_addr     (bus_addr),
        .bus_data_out (bus_data_out),
        .rsp_done     (rsp_done),
        .rsp_err      (rsp_err),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata)
    );

    assign bus_addr_stb_n = pins.as_n;
    assign bus_hi_stb_n   = pins.hi_n;
    assign bus_lo_stb_n   = pins.lo_n;
    assign bus_rd_wr_n    = pins.rw;
    assign bus_data_oe    = pins.oe;

endmodule

// File: tb/bus_cycle_master_tb.sv
`timescale 1ns/1ps
module bus_cycle_master_tb;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          req_write;
    logic [1:0]    req_be;
    logic [DW-1:0] req_wdata;
    logic          rsp_done, rsp_err, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_stb_n, bus_hi_stb_n, bus_lo_stb_n, bus_rd_wr_n, bus_data_oe;
    logic [DW-1:0] bus_data_out;
    logic [DW-1:0] bus_data_in;
    logic          bus_ack_n, bus_err_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bus_cycle_master #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_addr_stb_n(bus_addr_stb_n), .bus_hi_stb_n(bus_hi_stb_n),
        .bus_lo_stb_n(bus_lo_stb_n), .bus_rd_wr_n(bus_rd_wr_n), .bus_data_oe(bus_data_oe),
        .bus_data_out(bus_data_out), .bus_data_in(bus_data_in),
        .bus_ack_n(bus_ack_n), .bus_err_n(bus_err_n)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected state after the n-th edge following acceptance; 9 marks a wait half
    function automatic int st_at(input int n, input int m);
        if (n == 0) return 1;
        if (n == 1) return 2;
        if (n == 2) return 3;
        if (n >= 3 && n <= 3 + 2*m) return (((n - 3) % 2) == 0) ? 4 : 9;
        if (n == 4 + 2*m) return 5;
        if (n == 5 + 2*m) return 6;
        if (n == 6 + 2*m) return 7;
        return 0;
    endfunction

    // mode: 0 acknowledge, 1 bus error, 2 both
    task automatic run(input bit wr, input logic [1:0] be, input int k, input int mode, input int t);
        logic [AW-1:0] addr;
        logic [DW-1:0] wd, rd;
        int m, s, last;
        bit as_low, ds_low, rw_low, oe;
        addr = AW'(t * 32'h2f1d3 + 32'h51);
        wd   = DW'(t * 32'h3b7 + 32'h1a5);
        rd   = DW'(t * 32'h91d + 32'h4c2);
        m    = k / 2;
        last = 7 + 2*m;
        @(negedge clk);
        chk("R2", "ready before request", 32'(req_ready), 32'd1);
        req_valid   = 1'b1;
        req_addr    = addr;
        req_write   = wr;
        req_be      = be;
        req_wdata   = wd;
        bus_data_in = ~rd;
        for (int n = 0; n <= last; n++) begin
            @(negedge clk);
            if (n == 0) begin
                req_addr  = ~addr;
                req_wdata = ~wd;
                req_write = ~wr;
                req_be    = ~be;
            end
            if (n == k) begin
                if (mode != 1) bus_ack_n = 1'b0;
                if (mode != 0) bus_err_n = 1'b0;
            end
            if (n == 5 + 2*m) bus_data_in = rd;
            if (n == 6 + 2*m) req_valid = 1'b0;
            s      = st_at(n, m);
            as_low = s inside {2, 3, 4, 9, 5, 6};
            ds_low = wr ? (s inside {4, 9, 5, 6}) : as_low;
            rw_low = wr && (s inside {2, 3, 4, 9, 5, 6, 7});
            oe     = wr && (s inside {3, 4, 9, 5, 6, 7});
            chk(wr ? "R4" : "R3", "address strobe", 32'(bus_addr_stb_n), 32'(!as_low));
            if (s == 7) chk("R7", "strobe released", 32'(bus_addr_stb_n), 32'd1);
            chk("R5", "upper strobe", 32'(bus_hi_stb_n), 32'(!(ds_low && be[1])));
            chk("R5", "lower strobe", 32'(bus_lo_stb_n), 32'(!(ds_low && be[0])));
            chk("R4", "direction", 32'(bus_rd_wr_n), 32'(!rw_low));
            chk("R4", "data drive", 32'(bus_data_oe), 32'(oe));
            if (oe) chk("R4", "write data", 32'(bus_data_out), 32'(wd));
            if (s != 0) chk("R10", "address held", 32'(bus_addr), 32'(addr));
            chk("R2", "ready", 32'(req_ready), 32'(s == 0));
            chk("R6", "done timing", 32'(rsp_done), 32'(n == last));
            if (n == last) begin
                chk("R8", "direction back high", 32'(bus_rd_wr_n), 32'd1);
                chk("R9", "error flag", 32'(rsp_err), 32'(mode != 0));
                chk("R9", "read valid", 32'(rsp_valid), 32'(!wr && mode == 0));
                if (!wr && mode == 0) chk("R7", "read data", 32'(rsp_rdata), 32'(rd));
            end
        end
        @(negedge clk);
        chk("R8", "done is one tick", 32'(rsp_done), 32'd0);
        bus_ack_n = 1'b1;
        bus_err_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t;
        rst_n       = 1'b0;
        req_valid   = 1'b0;
        req_addr    = '0;
        req_write   = 1'b0;
        req_be      = 2'b00;
        req_wdata   = '0;
        bus_data_in = '0;
        bus_ack_n   = 1'b1;
        bus_err_n   = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", 32'(req_ready), 32'd1);
        chk("R1", "address strobe", 32'(bus_addr_stb_n), 32'd1);
        chk("R1", "upper strobe", 32'(bus_hi_stb_n), 32'd1);
        chk("R1", "lower strobe", 32'(bus_lo_stb_n), 32'd1);
        chk("R1", "direction", 32'(bus_rd_wr_n), 32'd1);
        chk("R1", "data drive", 32'(bus_data_oe), 32'd0);
        chk("R1", "done", 32'(rsp_done), 32'd0);
        t = 0;
        for (int wr = 0; wr < 2; wr++)
            for (int be = 1; be < 4; be++)
                for (int k = 0; k < 8; k++)
                    for (int mode = 0; mode < 3; mode++) begin
                        run(wr[0], be[1:0], k, mode, t);
                        t++;
                    end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule